// File: doc/BRIEF.md
# Stop-mode entry and wake controller

This block sequences a microcontroller's deepest power-down state. It watches the decoded-instruction stream for the stop opcode (8'h7F). It lets the core enter stop only when a protection key register was armed by writing 8'hA5 in an earlier cycle. While stopped, the oscillator enable and the gated core/peripheral clock enable are both low and the core is held. Register contents elsewhere are not touched.

Two events end a stop. The first is reset release. It clears the clock-divider select to the slow setting (2'b00) and clears the stabilisation select. It runs the stabilisation interval and then asks the core to load the restart address 16'h0100. The second is any of eight external interrupt lines, seen after a small synchroniser. It keeps the clock select and every other control field, and clears only the protection key. It runs the stabilisation interval programmed before entry. It then pulses a resume indication together with the lines that caused the wake, so the core can service them and continue after the stop instruction.

A stop opcode without an armed key produces a one-cycle illegal-stop pulse and has no other effect.

Top module: `stop_wake_ctrl`

## Requirements
- R1: With the key armed, a valid 8'h7F opcode sampled in the run state (clk_en_o=1) moves the block to stop at that edge. From the next cycle on, osc_en_o=0, clk_en_o=0 and core_hold_o=1.
- R2: Only a key write of exactly 8'hA5 arms the key. Any other write disarms it, and reset disarms it. A key write in the same cycle as the stop opcode does not count for that opcode.
- R3: In stop, osc_en_o=0, clk_en_o=0 and core_hold_o=1 hold until a wake event.
- R4: Any bit of irq_i held high wakes the block from stop. It is seen SYNC_STAGES edges late (default 2). In the run state, irq_i has no effect on the outputs.
- R5: Reset sets clk_sel_o to 2'b00 and the stabilisation select to 2'b00, whatever was written before.
- R6: After reset release, core_hold_o stays high for exactly 2^STAB_LOG[0] rising edges (256 by default). It falls in the cycle where pc_load_o pulses for one cycle with pc_vec_o = 16'h0100.
- R7: An interrupt wake leaves clk_sel_o unchanged and leaves the key disarmed.
- R8: After an interrupt wake, resume_o pulses for one cycle. It comes 2^N + SYNC_STAGES + 1 rising edges after the first edge that samples the interrupt. N is selected by ctl_stab_i (0..3 gives 8, 11, 13 or 16), and irq_svc_o shows the latched lines during the pulse (zero otherwise).
- R9: When reset arrives together with a stop-mode interrupt, the reset path wins: pc_load_o follows after the reset interval and resume_o never pulses.
- R10: A stop opcode in the run state with the key disarmed gives illegal_stop_o=1 for one cycle, and the block stays in run.
- R11: core_hold_o is always the inverse of clk_en_o. It falls only together with pc_load_o or resume_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | Decoded instruction valid |
| instr_op_i | input | 8 | Decoded opcode |
| key_wr_i | input | 1 | Write strobe for the protection key |
| key_data_i | input | 8 | Protection key write data |
| ctl_wr_i | input | 1 | Write strobe for the clock/stabilisation control |
| ctl_clksel_i | input | 2 | Clock-divider select write data |
| ctl_stab_i | input | 2 | Stabilisation interval select write data |
| irq_i | input | NIRQ | External wake interrupt lines |
| osc_en_o | output | 1 | Main oscillator enable |
| clk_en_o | output | 1 | Core and peripheral clock enable |
| core_hold_o | output | 1 | Holds the core |
| clk_sel_o | output | 2 | Clock-divider select |
| pc_load_o | output | 1 | One-cycle restart request |
| pc_vec_o | output | 16 | Restart address |
| resume_o | output | 1 | One-cycle resume-after-stop indication |
| irq_svc_o | output | NIRQ | Lines that caused the wake, valid with resume_o |
| illegal_stop_o | output | 1 | One-cycle pulse on an unkeyed stop opcode |

## Verification
The bench goes after the key ordering. A design that accepts a key written in the same cycle as the opcode, or keeps a key after a non-A5 write, after reset or after an interrupt wake, enters stop where it should pulse illegal_stop_o. It also measures the exact length of each stabilisation interval, so an off-by-one terminal count or a wrong synchroniser depth shows up as a wrong edge count. Reset and an interrupt are applied together during stop: a design that lets the interrupt win would pulse resume_o. Another would keep the programmed clock select instead of clearing it. Clock-select retention across an interrupt wake is checked with a non-default select and a non-default interval.

// File: rtl/swc_pkg.sv
package swc_pkg;
   typedef enum logic [1:0] {
      ST_RUN      = 2'd0,
      ST_STOP     = 2'd1,
      ST_WAKE_RST = 2'd2,
      ST_WAKE_INT = 2'd3
   } swc_state_e;

   localparam logic [7:0] STOP_OPCODE = 8'h7F;
   localparam logic [7:0] UNLOCK_KEY  = 8'hA5;
endpackage

// File: rtl/swc_key_guard.sv
module swc_key_guard #(
   parameter logic [7:0] KEY = 8'hA5
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       wr_i,
   input  logic [7:0] data_i,
   input  logic       clr_i,
   output logic       armed_o
);
   logic [7:0] key_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     key_q <= '0;
      else if (clr_i)  key_q <= '0;
      else if (wr_i)   key_q <= (data_i == KEY) ? data_i : '0;
   end

   assign armed_o = (key_q == KEY);
endmodule

// File: rtl/swc_wake_sync.sv
module swc_wake_sync #(
   parameter int unsigned NIRQ   = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NIRQ-1:0] irq_i,
   output logic [NIRQ-1:0] irq_o
);
   initial begin : p_param_chk
      assert (NIRQ >= 1 && NIRQ <= 32) else $fatal(1, "NIRQ out of range");
      assert (STAGES <= 4) else $fatal(1, "STAGES out of range");
   end

   generate
      if (STAGES == 0) begin : g_direct
         assign irq_o = irq_i;
      end else begin : g_sync
         logic [NIRQ-1:0] sr_q [STAGES];
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               for (int i = 0; i < STAGES; i++) sr_q[i] <= '0;
            end else begin
               sr_q[0] <= irq_i;
               for (int i = 1; i < STAGES; i++) sr_q[i] <= sr_q[i-1];
            end
         end
         assign irq_o = sr_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/swc_stab_timer.sv
module swc_stab_timer #(
   parameter int unsigned LOGS [4] = '{8, 11, 13, 16}
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       run_i,
   input  logic [1:0] sel_i,
   output logic       done_o
);
   function automatic int unsigned max_log();
      int unsigned m = 1;
      for (int i = 0; i < 4; i++) if (LOGS[i] > m) m = LOGS[i];
      return m;
   endfunction

   localparam int unsigned CW = max_log();

   initial begin : p_param_chk
      for (int i = 0; i < 4; i++)
         assert (LOGS[i] >= 1 && LOGS[i] <= 24) else $fatal(1, "stabilisation log out of range");
   end

   logic [CW-1:0] cnt_q;
   logic [3:0]    hit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (run_i)  cnt_q <= cnt_q + 1'b1;
      else             cnt_q <= '0;
   end

   generate
      for (genvar g = 0; g < 4; g++) begin : g_term
         localparam logic [CW-1:0] TERM = CW'((64'd1 << LOGS[g]) - 64'd1);
         assign hit[g] = (cnt_q == TERM);
      end
   endgenerate

   assign done_o = run_i && hit[sel_i];
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
   import swc_pkg::*;
#(
   parameter int unsigned NIRQ          = 8,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned STAB_LOG [4]  = '{8, 11, 13, 16},
   parameter logic [15:0] RESTART_ADDR  = 16'h0100
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            instr_valid_i,
   input  logic [7:0]      instr_op_i,
   input  logic            key_wr_i,
   input  logic [7:0]      key_data_i,
   input  logic            ctl_wr_i,
   input  logic [1:0]      ctl_clksel_i,
   input  logic [1:0]      ctl_stab_i,
   input  logic [NIRQ-1:0] irq_i,
   output logic            osc_en_o,
   output logic            clk_en_o,
   output logic            core_hold_o,
   output logic [1:0]      clk_sel_o,
   output logic            pc_load_o,
   output logic [15:0]     pc_vec_o,
   output logic            resume_o,
   output logic [NIRQ-1:0] irq_svc_o,
   output logic            illegal_stop_o
);
   swc_state_e      state_q;
   logic [1:0]      clksel_q;
   logic [1:0]      stabsel_q;
   logic [NIRQ-1:0] irq_lat_q;
   logic            pc_load_q;
   logic            resume_q;
   logic            illegal_q;
   logic [NIRQ-1:0] irq_s;
   logic            key_armed;
   logic            stab_done;
   logic            stop_req;
   logic            wake_irq;

   swc_wake_sync #(.NIRQ(NIRQ), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .irq_i  (irq_i),
      .irq_o  (irq_s)
   );

   assign stop_req = instr_valid_i && (instr_op_i == STOP_OPCODE) && (state_q == ST_RUN);
   assign wake_irq = (state_q == ST_STOP) && (|irq_s);

   swc_key_guard #(.KEY(UNLOCK_KEY)) u_key (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (key_wr_i && (state_q == ST_RUN)),
      .data_i  (key_data_i),
      .clr_i   (wake_irq),
      .armed_o (key_armed)
   );

   swc_stab_timer #(.LOGS(STAB_LOG)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  ((state_q == ST_WAKE_RST) || (state_q == ST_WAKE_INT)),
      .sel_i  (stabsel_q),
      .done_o (stab_done)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= ST_WAKE_RST;
         clksel_q  <= 2'b00;
         stabsel_q <= 2'b00;
         irq_lat_q <= '0;
         pc_load_q <= 1'b0;
         resume_q  <= 1'b0;
         illegal_q <= 1'b0;
      end else begin
         pc_load_q <= 1'b0;
         resume_q  <= 1'b0;
         illegal_q <= 1'b0;
         unique case (state_q)
            ST_RUN: begin
               if (ctl_wr_i) begin
                  clksel_q  <= ctl_clksel_i;
                  stabsel_q <= ctl_stab_i;
               end
               if (stop_req) begin
                  if (key_armed) state_q   <= ST_STOP;
                  else           illegal_q <= 1'b1;
               end
            end
            ST_STOP: begin
               if (wake_irq) begin
                  irq_lat_q <= irq_s;
                  state_q   <= ST_WAKE_INT;
               end
            end
            ST_WAKE_RST: begin
               if (stab_done) begin
                  state_q   <= ST_RUN;
                  pc_load_q <= 1'b1;
               end
            end
            ST_WAKE_INT: begin
               if (stab_done) begin
                  state_q  <= ST_RUN;
                  resume_q <= 1'b1;
               end
            end
            default: state_q <= ST_WAKE_RST;
         endcase
      end
   end

   assign osc_en_o       = (state_q != ST_STOP);
   assign clk_en_o       = (state_q == ST_RUN);
   assign core_hold_o    = (state_q != ST_RUN);
   assign clk_sel_o      = clksel_q;
   assign pc_load_o      = pc_load_q;
   assign pc_vec_o       = RESTART_ADDR;
   assign resume_o       = resume_q;
   assign irq_svc_o      = resume_q ? irq_lat_q : '0;
   assign illegal_stop_o = illegal_q;
endmodule

// File: rtl/swc_chk.sv
module swc_chk #(
   parameter int unsigned NIRQ         = 8,
   parameter logic [15:0] RESTART_ADDR = 16'h0100
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            instr_valid_i,
   input logic [7:0]      instr_op_i,
   input logic            key_armed,
   input logic            osc_en_o,
   input logic            clk_en_o,
   input logic            core_hold_o,
   input logic [1:0]      clk_sel_o,
   input logic            pc_load_o,
   input logic [15:0]     pc_vec_o,
   input logic            resume_o,
   input logic [NIRQ-1:0] irq_svc_o,
   input logic            illegal_stop_o
);
   logic stop_op;
   assign stop_op = instr_valid_i && (instr_op_i == 8'h7F) && clk_en_o;

   a_r1_keyed_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_op && key_armed) |=> (!osc_en_o && !clk_en_o));

   a_r10_unkeyed_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_op && !key_armed) |=> (illegal_stop_o && clk_en_o));

   a_r3_gated_in_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !osc_en_o |-> (!clk_en_o && core_hold_o));

   a_r11_hold_inverse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      core_hold_o != clk_en_o);

   a_r11_release_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(core_hold_o) |-> (pc_load_o != resume_o));

   a_r6_restart_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pc_load_o |-> (pc_vec_o == RESTART_ADDR && clk_sel_o == 2'b00));

   a_r7_clksel_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clk_en_o && $past(!clk_en_o)) |-> $stable(clk_sel_o));

   a_r7_key_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resume_o |-> !key_armed);

   a_r8_svc_with_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resume_o ? (irq_svc_o != '0) : (irq_svc_o == '0));
endmodule

bind stop_wake_ctrl swc_chk #(.NIRQ(NIRQ), .RESTART_ADDR(RESTART_ADDR)) u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .instr_valid_i  (instr_valid_i),
   .instr_op_i     (instr_op_i),
   .key_armed      (key_armed),
   .osc_en_o       (osc_en_o),
   .clk_en_o       (clk_en_o),
   .core_hold_o    (core_hold_o),
   .clk_sel_o      (clk_sel_o),
   .pc_load_o      (pc_load_o),
   .pc_vec_o       (pc_vec_o),
   .resume_o       (resume_o),
   .irq_svc_o      (irq_svc_o),
   .illegal_stop_o (illegal_stop_o)
);

// File: tb/stop_wake_ctrl_tb.sv
module stop_wake_ctrl_tb;
   localparam int NIRQ = 8;
   localparam int SYNC = 2;
   localparam int LOGS [4] = '{8, 11, 13, 16};

   typedef struct packed {
      logic       w1;
      logic [7:0] k1;
      logic       w2;
      logic [7:0] k2;
      logic       same;
      logic       exp_stop;
      logic [7:0] irq;
   } vec_t;

   localparam vec_t VEC [7] = '{
      '{1'b1, 8'hA5, 1'b0, 8'h00, 1'b0, 1'b1, 8'h01},
      '{1'b1, 8'hA4, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00},
      '{1'b1, 8'hA5, 1'b1, 8'h3C, 1'b0, 1'b0, 8'h00},
      '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00},
      '{1'b1, 8'hA5, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00},
      '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 8'h24},
      '{1'b1, 8'h5A, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic instr_valid = 1'b0;
   logic [7:0] instr_op = '0;
   logic key_wr = 1'b0;
   logic [7:0] key_data = '0;
   logic ctl_wr = 1'b0;
   logic [1:0] ctl_clksel = '0;
   logic [1:0] ctl_stab = '0;
   logic [NIRQ-1:0] irq = '0;
   logic osc_en, clk_en, core_hold, pc_load, resume, illegal;
   logic [1:0] clk_sel;
   logic [15:0] pc_vec;
   logic [NIRQ-1:0] irq_svc;

   int n_chk = 0;
   int n_fail = 0;
   int n_resume = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   stop_wake_ctrl u_dut (
      .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(instr_valid), .instr_op_i(instr_op),
      .key_wr_i(key_wr), .key_data_i(key_data), .ctl_wr_i(ctl_wr),
      .ctl_clksel_i(ctl_clksel), .ctl_stab_i(ctl_stab), .irq_i(irq),
      .osc_en_o(osc_en), .clk_en_o(clk_en), .core_hold_o(core_hold),
      .clk_sel_o(clk_sel), .pc_load_o(pc_load), .pc_vec_o(pc_vec),
      .resume_o(resume), .irq_svc_o(irq_svc), .illegal_stop_o(illegal)
   );

   always @(negedge clk) if (resume) n_resume++;

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog act=%0d exp<150000 cycles", cyc);
         report();
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // Counts rising edges until the selected pulse is seen at a falling edge.
   task automatic count_until(input bit want_resume, output int n);
      n = 0;
      for (int i = 0; i < 70000; i++) begin
         @(posedge clk); n++;
         @(negedge clk);
         if (want_resume ? resume : pc_load) break;
      end
   endtask

   task automatic do_stop();
      instr_valid = 1'b1; instr_op = 8'h7F;
      @(negedge clk);
      instr_valid = 1'b0; instr_op = 8'h00;
   endtask

   task automatic write_key(input logic [7:0] d);
      key_wr = 1'b1; key_data = d;
      @(negedge clk);
      key_wr = 1'b0;
   endtask

   task automatic wake_and_check(input string req, input logic [7:0] lines, input int lg, input logic [1:0] sel_exp);
      int n;
      irq = lines;
      count_until(1'b1, n);
      chk({req, " interrupt wake interval"}, n, (1 << lg) + SYNC + 1);
      chk({req, " irq_svc lines"}, irq_svc, lines);
      chk("R11 hold released with resume", core_hold, 1'b0);
      chk("R7 clk_sel kept", clk_sel, sel_exp);
      irq = '0;
      @(negedge clk);
      chk("R8 resume one cycle", resume, 1'b0);
   endtask

   initial begin
      int n;
      // Reset state
      @(negedge clk);
      chk("R5 clk_sel in reset", clk_sel, 2'b00);
      chk("R11 hold in reset", {core_hold, clk_en, osc_en}, 3'b101);
      rst_n = 1'b1;
      count_until(1'b0, n);
      chk("R6 reset interval", n, 1 << LOGS[0]);
      chk("R6 restart vector", pc_vec, 16'h0100);
      chk("R11 hold released with pc_load", {core_hold, clk_en}, 2'b01);
      @(negedge clk);
      chk("R6 pc_load one cycle", pc_load, 1'b0);

      // Table of key and stop patterns
      foreach (VEC[i]) begin
         if (VEC[i].w1) begin
            key_wr = 1'b1; key_data = VEC[i].k1;
            if (VEC[i].same) begin instr_valid = 1'b1; instr_op = 8'h7F; end
            @(negedge clk);
            key_wr = 1'b0; instr_valid = 1'b0;
         end
         if (VEC[i].w2) write_key(VEC[i].k2);
         if (!VEC[i].same) do_stop();
         if (VEC[i].exp_stop) begin
            chk("R1 stop entered", {osc_en, clk_en, core_hold}, 3'b001);
            repeat (5) @(negedge clk);
            chk("R3 stop held", {osc_en, clk_en, core_hold}, 3'b001);
            wake_and_check("R8", VEC[i].irq, LOGS[0], 2'b00);
         end else begin
            chk(VEC[i].same ? "R2 same-cycle key rejected" : "R10 illegal pulse",
                {illegal, clk_en}, 2'b11);
            @(negedge clk);
            chk("R10 illegal one cycle", {illegal, clk_en}, 2'b01);
         end
      end

      // Interrupt in run has no effect
      irq = 8'h02;
      repeat (5) @(negedge clk);
      chk("R4 irq ignored in run", {clk_en, resume, n_resume[7:0]}, {1'b1, 1'b0, 8'd2});
      irq = '0;

      // Non-default select and interval kept across interrupt wake
      ctl_wr = 1'b1; ctl_clksel = 2'b11; ctl_stab = 2'b01;
      @(negedge clk);
      ctl_wr = 1'b0;
      write_key(8'hA5);
      do_stop();
      chk("R1 stop entered with key", osc_en, 1'b0);
      wake_and_check("R8", 8'h10, LOGS[1], 2'b11);
      do_stop();
      chk("R7 key cleared by wake", illegal, 1'b1);

      // Reset and interrupt together during stop
      write_key(8'hA5);
      do_stop();
      chk("R3 stopped before reset", osc_en, 1'b0);
      n_resume = 0;
      irq = 8'h40; rst_n = 1'b0;
      @(negedge clk);
      chk("R5 clk_sel cleared by reset", clk_sel, 2'b00);
      rst_n = 1'b1;
      count_until(1'b0, n);
      chk("R9 reset path interval", n, 1 << LOGS[0]);
      irq = '0;
      repeat (3) @(negedge clk);
      chk("R9 no resume after reset", n_resume, 0);

      // Armed key lost through reset
      write_key(8'hA5);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      count_until(1'b0, n);
      do_stop();
      chk("R2 key cleared by reset", {illegal, clk_en}, 2'b11);

      report();
   end
endmodule